// File: doc/BRIEF.md
# Host Command Word Decoder

This block sits behind the receive side of a network socket and turns a stream of 16-bit words into single-cycle command strobes for the control logic of a trigger board. The stream is parsed in frames. Each frame opens with a delimiter word. A command word follows it, then a parameter word, and then up to two data words, depending on the command. The parser ignores any words that come before a delimiter, so a sender can always regain sync by sending a new frame.

A frame is acted on only when its last word has been accepted. The block then raises exactly one strobe for one cycle. Where the command carries an address or a value, the block latches it onto its address and data outputs in that same cycle. An automatic-send enable flag is held as a level. A crate reset command also drives a reset line for a fixed, parameterised number of clock cycles. If a frame carries a command or parameter code that the block does not know, the parser drops the frame and goes back to searching for the delimiter.

Top module: `cmd_word_decoder`

## Requirements
- R1: Words that arrive while the parser searches for the delimiter 0x0040 are discarded and raise no strobe. The first 0x0040 starts a frame: the next word is the command and the word after it is the parameter.
- R2: Command codes are one-hot: 0x0001 read, 0x0002 write, 0x0004 start, 0x0008 stop, 0x0010 ping, 0x0020 crate reset, 0x0040 autosend, 0x0080 board configure. For read, parameter 0x0001 raises strobe bit 0 (static block read) and parameter 0x0002 raises bit 1 (dynamic block read).
- R3: Read with parameter 0x0004 takes one more word, raises strobe bit 2, and shows the low ADDR_W bits of that word on addr_o.
- R4: Write with parameter 0x0001 raises strobe bit 3. Write with parameter 0x0004 takes an address word and then a data word, raises strobe bit 4, and shows them on addr_o and data_o.
- R5: Autosend with parameter 0x0001 or 0x0000 raises strobe bit 6 and sets autosend_o to the parameter's bit 0. Any other value is ignored.
- R6: Start with parameter 0x0001 raises strobe bit 7 (free run). Start with parameter 0x0002 takes one more word, raises strobe bit 8 and shows the event count on data_o.
- R7: Stop, ping and crate reset each need a parameter word but ignore its value; they raise strobe bits 9, 5 and 10. Board configure raises strobe bit 11 and shows the low ADDR_W bits of its parameter (the board index) on addr_o.
- R8: After a crate reset strobe, crate_rst_o goes high on the next cycle and stays high for exactly RST_CYCLES cycles (default 50). A new crate reset command restarts the count.
- R9: An unknown command code, or a parameter that is not valid for its command, sends the parser back to the delimiter search without raising any strobe.
- R10: A strobe is high for one cycle only, in the cycle after the frame's last word is accepted. At most one strobe bit is high at any time.
- R11: After reset, strobe_o, addr_o, data_o, autosend_o and crate_rst_o are all zero.
- R12: Cycles with word_valid low do not advance the parser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | Input word is present this cycle |
| word_data | input | 16 | Input word |
| strobe_o | output | 12 | One-cycle command strobes, bit positions as in R2 to R7 |
| addr_o | output | ADDR_W | Latched address or board index |
| data_o | output | 16 | Latched write data or event count |
| autosend_o | output | 1 | Automatic-send enable level |
| crate_rst_o | output | 1 | Timed crate reset line |

## Verification
If the parser's state is wrong, the next complete frame shows it at the ports. The expected strobe may be missing, a different strobe bit may rise, or the strobe may come one cycle early or late because a word was consumed in the wrong state. The bench applies a table of frames and compares strobe_o, addr_o, data_o and autosend_o in the cycle after each final word, and again one cycle later. A corrupted reset counter shows as a crate_rst_o pulse whose length differs from RST_CYCLES, and the bench measures the pulse length cycle by cycle.

// File: rtl/hcmd_pkg.sv
package hcmd_pkg;
  localparam int WORD_W = 16;
  localparam int NSTB   = 12;

  localparam logic [WORD_W-1:0] DELIM    = 16'h0040;
  localparam logic [WORD_W-1:0] C_READ   = 16'h0001;
  localparam logic [WORD_W-1:0] C_WRITE  = 16'h0002;
  localparam logic [WORD_W-1:0] C_START  = 16'h0004;
  localparam logic [WORD_W-1:0] C_STOP   = 16'h0008;
  localparam logic [WORD_W-1:0] C_PING   = 16'h0010;
  localparam logic [WORD_W-1:0] C_CRST   = 16'h0020;
  localparam logic [WORD_W-1:0] C_ASEND  = 16'h0040;
  localparam logic [WORD_W-1:0] C_CFG    = 16'h0080;

  localparam logic [WORD_W-1:0] P_ONE    = 16'h0001;
  localparam logic [WORD_W-1:0] P_TWO    = 16'h0002;
  localparam logic [WORD_W-1:0] P_FOUR   = 16'h0004;
  localparam logic [WORD_W-1:0] P_ZERO   = 16'h0000;

  // strobe bit positions
  localparam int S_RDS  = 0;
  localparam int S_RDD  = 1;
  localparam int S_RDA  = 2;
  localparam int S_WRS  = 3;
  localparam int S_WRA  = 4;
  localparam int S_PING = 5;
  localparam int S_AS   = 6;
  localparam int S_RUN  = 7;
  localparam int S_RUNN = 8;
  localparam int S_STOP = 9;
  localparam int S_CRST = 10;
  localparam int S_CFG  = 11;

  typedef enum logic [2:0] {
    ST_HUNT = 3'd0,
    ST_CMD  = 3'd1,
    ST_PAR  = 3'd2,
    ST_D1   = 3'd3,
    ST_D2   = 3'd4
  } pstate_t;
endpackage

// File: rtl/hcmd_decode.sv
module hcmd_decode
  import hcmd_pkg::*;
(
  input  logic [WORD_W-1:0] cmd,
  input  logic [WORD_W-1:0] par,
  output logic              cmd_known,
  output logic              par_ok,
  output logic [1:0]        n_extra,
  output logic [NSTB-1:0]   stb
);
  always_comb begin
    cmd_known = 1'b1;
    par_ok    = 1'b0;
    n_extra   = 2'd0;
    stb       = '0;
    case (cmd)
      C_READ: begin
        if (par == P_ONE) begin
          par_ok = 1'b1; stb[S_RDS] = 1'b1;
        end else if (par == P_TWO) begin
          par_ok = 1'b1; stb[S_RDD] = 1'b1;
        end else if (par == P_FOUR) begin
          par_ok = 1'b1; stb[S_RDA] = 1'b1; n_extra = 2'd1;
        end
      end
      C_WRITE: begin
        if (par == P_ONE) begin
          par_ok = 1'b1; stb[S_WRS] = 1'b1;
        end else if (par == P_FOUR) begin
          par_ok = 1'b1; stb[S_WRA] = 1'b1; n_extra = 2'd2;
        end
      end
      C_START: begin
        if (par == P_ONE) begin
          par_ok = 1'b1; stb[S_RUN] = 1'b1;
        end else if (par == P_TWO) begin
          par_ok = 1'b1; stb[S_RUNN] = 1'b1; n_extra = 2'd1;
        end
      end
      C_STOP: begin
        par_ok = 1'b1; stb[S_STOP] = 1'b1;
      end
      C_PING: begin
        par_ok = 1'b1; stb[S_PING] = 1'b1;
      end
      C_CRST: begin
        par_ok = 1'b1; stb[S_CRST] = 1'b1;
      end
      C_ASEND: begin
        if (par == P_ONE || par == P_ZERO) begin
          par_ok = 1'b1; stb[S_AS] = 1'b1;
        end
      end
      C_CFG: begin
        par_ok = 1'b1; stb[S_CFG] = 1'b1;
      end
      default: cmd_known = 1'b0;
    endcase
  end
endmodule

// File: rtl/hcmd_fsm.sv
module hcmd_fsm
  import hcmd_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [WORD_W-1:0] word,
  output logic [NSTB-1:0]   stb_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [WORD_W-1:0] data_q,
  output logic              as_q
);
  pstate_t           state;
  logic [WORD_W-1:0] cmd_q;
  logic [WORD_W-1:0] par_q;
  logic [ADDR_W-1:0] d1_q;
  logic [WORD_W-1:0] par_sel;
  logic              cmd_known;
  logic              par_ok;
  logic [1:0]        n_extra;
  logic [NSTB-1:0]   dec_stb;
  logic              cmd_known_w;
  logic              unused_a, unused_b;
  logic [1:0]        unused_n;
  logic [NSTB-1:0]   unused_s;

  assign par_sel = (state == ST_PAR) ? word : par_q;

  hcmd_decode u_dec (
    .cmd       (cmd_q),
    .par       (par_sel),
    .cmd_known (cmd_known),
    .par_ok    (par_ok),
    .n_extra   (n_extra),
    .stb       (dec_stb)
  );

  // early check of the command word itself
  hcmd_decode u_cmdchk (
    .cmd       (word),
    .par       (P_ZERO),
    .cmd_known (cmd_known_w),
    .par_ok    (unused_a),
    .n_extra   (unused_n),
    .stb       (unused_s)
  );
  assign unused_b = cmd_known;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_HUNT;
      cmd_q  <= '0;
      par_q  <= '0;
      d1_q   <= '0;
      stb_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
      as_q   <= 1'b0;
    end else begin
      stb_q <= '0;
      if (valid) begin
        case (state)
          ST_HUNT: if (word == DELIM) state <= ST_CMD;
          ST_CMD: begin
            if (cmd_known_w) begin
              cmd_q <= word;
              state <= ST_PAR;
            end else begin
              state <= ST_HUNT;
            end
          end
          ST_PAR: begin
            par_q <= word;
            if (!par_ok) begin
              state <= ST_HUNT;
            end else if (n_extra == 2'd0) begin
              stb_q <= dec_stb;
              state <= ST_HUNT;
              if (dec_stb[S_AS])  as_q   <= word[0];
              if (dec_stb[S_CFG]) addr_q <= word[ADDR_W-1:0];
            end else begin
              state <= ST_D1;
            end
          end
          ST_D1: begin
            if (n_extra == 2'd1) begin
              stb_q <= dec_stb;
              state <= ST_HUNT;
              if (dec_stb[S_RDA])  addr_q <= word[ADDR_W-1:0];
              if (dec_stb[S_RUNN]) data_q <= word;
            end else begin
              d1_q  <= word[ADDR_W-1:0];
              state <= ST_D2;
            end
          end
          ST_D2: begin
            stb_q  <= dec_stb;
            addr_q <= d1_q;
            data_q <= word;
            state  <= ST_HUNT;
          end
          default: state <= ST_HUNT;
        endcase
      end
    end
  end

  p_onehot_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stb_q));
  p_single_cycle_r10: assert property (@(posedge clk) disable iff (rst)
    (stb_q != '0) |=> (stb_q == '0));
  p_hunt_discard_r1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HUNT && valid && word != DELIM) |=> (state == ST_HUNT && stb_q == '0));
  p_stall_r12: assert property (@(posedge clk) disable iff (rst)
    (!valid) |=> (stb_q == '0 && $stable(state)));
  p_unknown_cmd_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CMD && valid && !cmd_known_w) |=> (state == ST_HUNT && stb_q == '0));
  p_autosend_src_r5: assert property (@(posedge clk) disable iff (rst)
    (!$stable(as_q)) |-> stb_q[S_AS]);
endmodule

// File: rtl/hcmd_rst_timer.sv
module hcmd_rst_timer #(
  parameter int RST_CYCLES = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic line
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(RST_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (trig)        cnt <= LOAD;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign line = (cnt != '0);

  p_line_start_r8: assert property (@(posedge clk) disable iff (rst)
    trig |=> line);
  p_line_cause_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(line) |-> $past(trig));
endmodule

// File: rtl/cmd_word_decoder.sv
module cmd_word_decoder
  import hcmd_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int RST_CYCLES = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_valid,
  input  logic [15:0]       word_data,
  output logic [11:0]       strobe_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [15:0]       data_o,
  output logic              autosend_o,
  output logic              crate_rst_o
);
  logic [NSTB-1:0] stb;

  hcmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk    (clk),
    .rst    (rst),
    .valid  (word_valid),
    .word   (word_data),
    .stb_q  (stb),
    .addr_q (addr_o),
    .data_q (data_o),
    .as_q   (autosend_o)
  );

  hcmd_rst_timer #(.RST_CYCLES(RST_CYCLES)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .trig (stb[S_CRST]),
    .line (crate_rst_o)
  );

  assign strobe_o = stb;

  p_reset_clear_r11: assert property (@(posedge clk)
    $past(rst) |-> (strobe_o == '0 && !crate_rst_o && !autosend_o));
endmodule

// File: tb/sim_cmd_word_decoder.sv
module sim_cmd_word_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  typedef struct packed {
    logic [2:0]  n;
    logic [79:0] w;
    logic [11:0] stb;
    logic        chk;
    logic [11:0] addr;
    logic [15:0] dat;
    logic        as;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{3'd3, {16'h0,16'h0,16'h0001,16'h0001,16'h0040}, 12'h001, 1'b0, 12'h000, 16'h0000, 1'b0},
    '{3'd3, {16'h0,16'h0,16'h0002,16'h0001,16'h0040}, 12'h002, 1'b0, 12'h000, 16'h0000, 1'b0},
    '{3'd4, {16'h0,16'h0123,16'h0004,16'h0001,16'h0040}, 12'h004, 1'b1, 12'h123, 16'h0000, 1'b0},
    '{3'd3, {16'h0,16'h0,16'h0001,16'h0002,16'h0040}, 12'h008, 1'b0, 12'h000, 16'h0000, 1'b0},
    '{3'd5, {16'hBEEF,16'h0ABC,16'h0004,16'h0002,16'h0040}, 12'h010, 1'b1, 12'hABC, 16'hBEEF, 1'b0},
    '{3'd3, {16'h0,16'h0,16'h1234,16'h0010,16'h0040}, 12'h020, 1'b0, 12'h000, 16'h0000, 1'b0},
    '{3'd3, {16'h0,16'h0,16'h0001,16'h0040,16'h0040}, 12'h040, 1'b0, 12'h000, 16'h0000, 1'b1},
    '{3'd3, {16'h0,16'h0,16'h0001,16'h0004,16'h0040}, 12'h080, 1'b0, 12'h000, 16'h0000, 1'b1},
    '{3'd4, {16'h0,16'h03E8,16'h0002,16'h0004,16'h0040}, 12'h100, 1'b1, 12'hABC, 16'h03E8, 1'b1},
    '{3'd3, {16'h0,16'h0,16'hFFFF,16'h0008,16'h0040}, 12'h200, 1'b0, 12'h000, 16'h0000, 1'b1},
    '{3'd3, {16'h0,16'h0,16'h0007,16'h0080,16'h0040}, 12'h800, 1'b1, 12'h007, 16'h03E8, 1'b1},
    '{3'd3, {16'h0,16'h0,16'h0000,16'h0040,16'h0040}, 12'h040, 1'b0, 12'h000, 16'h0000, 1'b0},
    '{3'd5, {16'h0001,16'h0001,16'h0040,16'h2222,16'h1111}, 12'h001, 1'b0, 12'h000, 16'h0000, 1'b0},
    '{3'd2, {16'h0,16'h0,16'h0,16'h0003,16'h0040}, 12'h000, 1'b1, 12'h007, 16'h03E8, 1'b0},
    '{3'd3, {16'h0,16'h0,16'h0008,16'h0001,16'h0040}, 12'h000, 1'b1, 12'h007, 16'h03E8, 1'b0},
    '{3'd3, {16'h0,16'h0,16'h0002,16'h0002,16'h0040}, 12'h000, 1'b1, 12'h007, 16'h03E8, 1'b0},
    '{3'd3, {16'h0,16'h0,16'h0003,16'h0004,16'h0040}, 12'h000, 1'b1, 12'h007, 16'h03E8, 1'b0},
    '{3'd3, {16'h0,16'h0,16'h0002,16'h0040,16'h0040}, 12'h000, 1'b1, 12'h007, 16'h03E8, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_valid = 1'b0;
  logic [15:0] word_data = '0;
  logic [11:0] strobe_o;
  logic [11:0] addr_o;
  logic [15:0] data_o;
  logic        autosend_o;
  logic        crate_rst_o;

  int checks = 0;
  int fails  = 0;

  cmd_word_decoder #(.ADDR_W(12), .RST_CYCLES(50)) u0 (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word_data(word_data),
    .strobe_o(strobe_o), .addr_o(addr_o), .data_o(data_o),
    .autosend_o(autosend_o), .crate_rst_o(crate_rst_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] w);
    word_valid = 1'b1;
    word_data  = w;
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  task automatic crst_frame();
    put(16'h0040); put(16'h0020); put(16'h5A5A);
  endtask

  int hi;

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11: reset state
    check(strobe_o == 0 && addr_o == 0 && data_o == 0 && !autosend_o && !crate_rst_o,
          "R11", {strobe_o, addr_o, data_o, autosend_o, crate_rst_o}, 64'h0);

    // table walk: R1..R7, R9, R10
    for (int v = 0; v < NV; v++) begin
      bit ok;
      ok = 1'b1;
      for (int i = 0; i < int'(VECS[v].n); i++) begin
        put(VECS[v].w[i*16 +: 16]);
        if (i < int'(VECS[v].n) - 1 && strobe_o != 0) ok = 1'b0;
      end
      if (strobe_o != VECS[v].stb || autosend_o != VECS[v].as) ok = 1'b0;
      if (VECS[v].chk && (addr_o != VECS[v].addr || data_o != VECS[v].dat)) ok = 1'b0;
      check(ok, $sformatf("R2-table vec%0d (R1 R3 R4 R5 R6 R7 R9)", v),
            {strobe_o, addr_o, data_o, 3'b0, autosend_o},
            {VECS[v].stb, VECS[v].addr, VECS[v].dat, 3'b0, VECS[v].as});
      @(negedge clk);
      check(strobe_o == 0, $sformatf("R10 vec%0d one-cycle strobe", v), 64'(strobe_o), 64'h0);
    end

    // R12: gaps in word_valid do not advance
    put(16'h0040);
    word_data = 16'h0001;
    repeat (3) @(negedge clk);
    check(strobe_o == 0, "R12 gap no strobe", 64'(strobe_o), 64'h0);
    put(16'h0001);
    @(negedge clk);
    put(16'h0001);
    check(strobe_o == 12'h001, "R12 frame across gaps", 64'(strobe_o), 64'h001);

    // R8: crate reset pulse length
    @(negedge clk);
    crst_frame();
    check(strobe_o == 12'h400 && !crate_rst_o, "R8 strobe then line", {strobe_o, 3'b0, crate_rst_o}, {12'h400, 4'h0});
    hi = 0;
    @(negedge clk);
    while (crate_rst_o && hi < 200) begin hi++; @(negedge clk); end
    check(hi == 50, "R8 pulse length", 64'(hi), 64'd50);

    // R8: retrigger restarts the count
    crst_frame();
    repeat (20) @(negedge clk);
    check(crate_rst_o, "R8 line high mid pulse", 64'(crate_rst_o), 64'h1);
    crst_frame();
    check(strobe_o == 12'h400, "R8 retrigger strobe", 64'(strobe_o), 64'h400);
    hi = 0;
    @(negedge clk);
    while (crate_rst_o && hi < 200) begin hi++; @(negedge clk); end
    check(hi == 50, "R8 retrigger pulse length", 64'(hi), 64'd50);

    // R11: reset in the middle of a frame drops it
    put(16'h0040); put(16'h0001);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    put(16'h0001);
    check(strobe_o == 0 && addr_o == 0 && data_o == 0, "R11 mid-frame reset", {strobe_o, addr_o, data_o}, 64'h0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule